// File: doc/BRIEF.md
# I2C Master Command and Receive Queues

This block buffers traffic between software and the bus engine of an I2C master. Software pushes command words into a transmit-side queue. Each word holds one byte to send and three control flags: read request, STOP after the byte, and repeated START before it. The bus engine takes the oldest command through a valid/ready handshake. It returns each byte it reads from the bus into a receive queue, and software pops those bytes through a read port.

Both queue levels are visible to software. Two level flags compare those levels against programmable thresholds. Three one-cycle error pulses report a command written into a full queue, a received byte arriving at a full queue, and a read of an empty queue. All of these go to an interrupt block. A flush input, raised when a transfer aborts, empties both queues in a single cycle.

Top module: `i2c_xfer_fifos`

## Requirements
- R1: A command word uses bits 7:0 for the byte, bit 8 for the read request, bit 9 for STOP-after and bit 10 for restart-before. Entries reach the engine in write order on cmdByte/cmdRead/cmdStop/cmdRestart. cmdValid is high while the command queue holds an entry, and the head entry leaves on a cycle where cmdValid and cmdReady are both high.
- R2: For an entry with the read bit set, the data field is ignored, and cmdByte is presented as 8'h00.
- R3: txLevel and rxLevel equal the number of entries held, from 0 up to the queue depth.
- R4: txEmptyFlag is high exactly while txLevel is less than or equal to txThresh.
- R5: rxFullFlag is high exactly while rxLevel is greater than rxThresh, so a threshold of 0 asserts it with one entry.
- R6: A command write while the command queue is full is dropped, even if an entry leaves in the same cycle. txOverFlag is then high for the single following cycle.
- R7: A received byte pushed while the receive queue is full is dropped, even if software pops in the same cycle. rxOverFlag is then high for the single following cycle.
- R8: A read while the receive queue is empty returns zero and leaves the level at 0. rxUnderFlag is then high for the single following cycle.
- R9: rxRdData shows the oldest received byte in bits 7:0 with bits 10:8 zero, and rxRdEn removes it. Bytes come out in arrival order.
- R10: flush empties both queues by the next cycle. Every write, read, hand-off and push in the flush cycle is ignored and raises no error pulse.
- R11: Under reset both levels are 0, cmdValid is low, rxFullFlag and all error pulses are low, and txEmptyFlag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWrData | input | 11 | Command word |
| rxRdEn | input | 1 | Receive read (pop) strobe |
| rxRdData | output | 11 | Oldest received byte, zero-extended |
| txThresh | input | LVL_W | Command queue level threshold |
| rxThresh | input | LVL_W | Receive queue level threshold |
| txLevel | output | LVL_W | Command queue fill level |
| rxLevel | output | LVL_W | Receive queue fill level |
| flush | input | 1 | Abort flush of both queues |
| txEmptyFlag | output | 1 | Command level at or below threshold |
| rxFullFlag | output | 1 | Receive level above threshold |
| txOverFlag | output | 1 | Pulse: command write dropped |
| rxOverFlag | output | 1 | Pulse: received byte dropped |
| rxUnderFlag | output | 1 | Pulse: empty receive queue read |
| cmdValid | output | 1 | Head command available |
| cmdReady | input | 1 | Engine accepts head command |
| cmdByte | output | 8 | Head command byte |
| cmdRead | output | 1 | Head command is a read request |
| cmdStop | output | 1 | Head command requests STOP after |
| cmdRestart | output | 1 | Head command requests restart before |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |

## Verification
The bench targets these cases:
- A write into a full command queue while the engine drains it in the same cycle. A design that let the write through would lose track of its level.
- A push into a full receive queue paired with a pop. Mishandling this case either corrupts ordering or leaves no error pulse.
- A flush in a cycle that also writes, reads, pushes and hands off. A design that did not give flush priority would leave an entry behind or raise a false error pulse.
- Read requests whose data field carries nonzero bits. A design that forwarded those bits would show them on cmdByte.
- Thresholds swept across their whole range, including 0 and the full depth. An off-by-one in either comparison would misreport a flag exactly at the threshold level.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int CMD_W        = 11;
  localparam int BYTE_W       = 8;
  localparam int CMD_RD_BIT   = 8;
  localparam int CMD_STOP_BIT = 9;
  localparam int CMD_RS_BIT   = 10;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic clear;
  } fifoStrobes_t;
endpackage

// File: rtl/i2c_fifo_store.sv
module i2c_fifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
endmodule

// File: rtl/i2c_fifo_ctrl.sv
module i2c_fifo_ctrl
  import i2c_fifo_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic             rxRdEn,
  input  logic             cmdReady,
  input  logic             rxPush,
  input  logic             flush,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txThresh,
  input  logic [LVL_W-1:0] rxThresh,
  output fifoStrobes_t     strobes,
  output logic             cmdValid,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverFlag,
  output logic             rxOverFlag,
  output logic             rxUnderFlag
);
  assign cmdValid = !txEmpty;

  always_comb begin
    strobes.clear  = flush;
    strobes.txPush = cmdWrEn && !txFull && !flush;
    strobes.txPop  = cmdValid && cmdReady && !flush;
    strobes.rxPush = rxPush && !rxFull && !flush;
    strobes.rxPop  = rxRdEn && !rxEmpty && !flush;
  end

  assign txEmptyFlag = (txLevel <= txThresh);
  assign rxFullFlag  = (rxLevel > rxThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverFlag  <= 1'b0;
      rxOverFlag  <= 1'b0;
      rxUnderFlag <= 1'b0;
    end else begin
      txOverFlag  <= cmdWrEn && txFull && !flush;
      rxOverFlag  <= rxPush && rxFull && !flush;
      rxUnderFlag <= rxRdEn && rxEmpty && !flush;
    end
  end
endmodule

// File: rtl/i2c_xfer_fifos.sv
module i2c_xfer_fifos
  import i2c_fifo_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int LVL_W = $clog2(((TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [10:0]      cmdWrData,
  input  logic             rxRdEn,
  output logic [10:0]      rxRdData,
  input  logic [LVL_W-1:0] txThresh,
  input  logic [LVL_W-1:0] rxThresh,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  input  logic             flush,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverFlag,
  output logic             rxOverFlag,
  output logic             rxUnderFlag,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic [7:0]       cmdByte,
  output logic             cmdRead,
  output logic             cmdStop,
  output logic             cmdRestart,
  input  logic             rxPush,
  input  logic [7:0]       rxByte
);
  localparam int TX_CNT_W = $clog2(TX_DEPTH + 1);
  localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);

  fifoStrobes_t strobes;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic [TX_CNT_W-1:0] txCount;
  logic [RX_CNT_W-1:0] rxCount;
  logic [CMD_W-1:0] txIn, txHead;
  logic [BYTE_W-1:0] rxHead;

  // read requests carry no payload: zero the byte before it is stored
  assign txIn = {cmdWrData[CMD_W-1:CMD_RD_BIT],
                 cmdWrData[CMD_RD_BIT] ? BYTE_W'(0) : cmdWrData[BYTE_W-1:0]};

  i2c_fifo_store #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txStore (
    .clk(clk), .rstN(rstN), .clear(strobes.clear),
    .push(strobes.txPush), .pop(strobes.txPop), .wData(txIn),
    .headData(txHead), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  i2c_fifo_store #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxStore (
    .clk(clk), .rstN(rstN), .clear(strobes.clear),
    .push(strobes.rxPush), .pop(strobes.rxPop), .wData(rxByte),
    .headData(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign txLevel = LVL_W'(txCount);
  assign rxLevel = LVL_W'(rxCount);

  i2c_fifo_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .rxRdEn(rxRdEn),
    .cmdReady(cmdReady), .rxPush(rxPush), .flush(flush),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txLevel(txLevel), .rxLevel(rxLevel), .txThresh(txThresh), .rxThresh(rxThresh),
    .strobes(strobes), .cmdValid(cmdValid), .txEmptyFlag(txEmptyFlag),
    .rxFullFlag(rxFullFlag), .txOverFlag(txOverFlag), .rxOverFlag(rxOverFlag),
    .rxUnderFlag(rxUnderFlag)
  );

  assign cmdByte    = txHead[BYTE_W-1:0];
  assign cmdRead    = txHead[CMD_RD_BIT];
  assign cmdStop    = txHead[CMD_STOP_BIT];
  assign cmdRestart = txHead[CMD_RS_BIT];
  assign rxRdData   = rxEmpty ? '0 : {{(CMD_W - BYTE_W){1'b0}}, rxHead};
endmodule

// File: rtl/i2c_xfer_fifos_chk.sv
module i2c_xfer_fifos_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdWrEn,
  input logic             rxRdEn,
  input logic             rxPush,
  input logic             flush,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             cmdValid,
  input logic             cmdRead,
  input logic [7:0]       cmdByte,
  input logic             txOverFlag,
  input logic             rxOverFlag,
  input logic             rxUnderFlag
);
  assert_read_byte_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdRead) |-> (cmdByte == 8'h00));

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(TX_DEPTH)) && (rxLevel <= LVL_W'(RX_DEPTH)));

  assert_tx_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !flush && txLevel == LVL_W'(TX_DEPTH)) |=> txOverFlag);

  assert_rx_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !flush && rxLevel == LVL_W'(RX_DEPTH)) |=> (rxOverFlag && rxLevel <= $past(rxLevel)));

  assert_rx_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && !flush && rxLevel == '0) |=> rxUnderFlag);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (txLevel == '0 && rxLevel == '0 && !txOverFlag && !rxOverFlag && !rxUnderFlag));
endmodule

bind i2c_xfer_fifos i2c_xfer_fifos_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .rxRdEn(rxRdEn), .rxPush(rxPush),
  .flush(flush), .txLevel(txLevel), .rxLevel(rxLevel), .cmdValid(cmdValid),
  .cmdRead(cmdRead), .cmdByte(cmdByte), .txOverFlag(txOverFlag),
  .rxOverFlag(rxOverFlag), .rxUnderFlag(rxUnderFlag)
);

// File: tb/i2c_xfer_fifos_bench.sv
module i2c_xfer_fifos_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 8;
  localparam int RXD = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 0, rxRdEn = 0, flush = 0, cmdReady = 0, rxPush = 0;
  logic [10:0] cmdWrData = '0;
  logic [7:0] rxByte = '0;
  logic [LW-1:0] txThresh = LW'(4), rxThresh = '0;
  logic [10:0] rxRdData;
  logic [LW-1:0] txLevel, rxLevel;
  logic txEmptyFlag, rxFullFlag, txOverFlag, rxOverFlag, rxUnderFlag;
  logic cmdValid, cmdRead, cmdStop, cmdRestart;
  logic [7:0] cmdByte;

  int checks = 0;
  int errors = 0;
  logic [10:0] txQ[$];
  logic [7:0] rxQ[$];
  logic expTxOver = 0, expRxOver = 0, expUnder = 0, lastFlush = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_fifos #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_i2c_xfer_fifos (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .rxRdEn(rxRdEn), .rxRdData(rxRdData), .txThresh(txThresh), .rxThresh(rxThresh),
    .txLevel(txLevel), .rxLevel(rxLevel), .flush(flush), .txEmptyFlag(txEmptyFlag),
    .rxFullFlag(rxFullFlag), .txOverFlag(txOverFlag), .rxOverFlag(rxOverFlag),
    .rxUnderFlag(rxUnderFlag), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdByte(cmdByte), .cmdRead(cmdRead), .cmdStop(cmdStop), .cmdRestart(cmdRestart),
    .rxPush(rxPush), .rxByte(rxByte)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expHeadByte(input logic [10:0] w);
    return w[8] ? 8'h00 : w[7:0];
  endfunction

  task automatic compareOutputs();
    string lvlTag;
    lvlTag = lastFlush ? "R10" : "R3";
    check(int'(txLevel) == txQ.size(), {lvlTag, " txLevel"}, int'(txLevel), txQ.size());
    check(int'(rxLevel) == rxQ.size(), {lvlTag, " rxLevel"}, int'(rxLevel), rxQ.size());
    check(cmdValid == (txQ.size() > 0), "R1 cmdValid", int'(cmdValid), int'(txQ.size() > 0));
    if (txQ.size() > 0) begin
      check(cmdByte == expHeadByte(txQ[0]), txQ[0][8] ? "R2 cmdByte" : "R1 cmdByte",
            int'(cmdByte), int'(expHeadByte(txQ[0])));
      check({cmdRestart, cmdStop, cmdRead} == txQ[0][10:8], "R1 flags",
            int'({cmdRestart, cmdStop, cmdRead}), int'(txQ[0][10:8]));
    end
    if (rxQ.size() > 0)
      check(rxRdData == {3'b000, rxQ[0]}, "R9 rxRdData", int'(rxRdData), int'(rxQ[0]));
    else
      check(rxRdData == '0, "R8 rxRdData empty", int'(rxRdData), 0);
    check(txEmptyFlag == (txQ.size() <= int'(txThresh)), "R4 txEmptyFlag",
          int'(txEmptyFlag), int'(txQ.size() <= int'(txThresh)));
    check(rxFullFlag == (rxQ.size() > int'(rxThresh)), "R5 rxFullFlag",
          int'(rxFullFlag), int'(rxQ.size() > int'(rxThresh)));
    check(txOverFlag == expTxOver, "R6 txOverFlag", int'(txOverFlag), int'(expTxOver));
    check(rxOverFlag == expRxOver, "R7 rxOverFlag", int'(rxOverFlag), int'(expRxOver));
    check(rxUnderFlag == expUnder, "R8 rxUnderFlag", int'(rxUnderFlag), int'(expUnder));
  endtask

  // drive one cycle, check pre-edge outputs, advance the model
  task automatic step(input logic wr, input logic [10:0] wd, input logic rd,
                      input logic rdy, input logic push, input logic [7:0] pb,
                      input logic fl);
    logic txF, rxF, rxE, txNE;
    cmdWrEn = wr; cmdWrData = wd; rxRdEn = rd; cmdReady = rdy;
    rxPush = push; rxByte = pb; flush = fl;
    #1;
    compareOutputs();
    txF = (txQ.size() == TXD); rxF = (rxQ.size() == RXD);
    rxE = (rxQ.size() == 0); txNE = (txQ.size() > 0);
    if (fl) begin
      txQ.delete(); rxQ.delete();
      expTxOver = 0; expRxOver = 0; expUnder = 0;
    end else begin
      expTxOver = wr && txF;
      expRxOver = push && rxF;
      expUnder  = rd && rxE;
      if (rdy && txNE) void'(txQ.pop_front());
      if (rd && !rxE) void'(rxQ.pop_front());
      if (wr && !txF) txQ.push_back(wd);
      if (push && !rxF) rxQ.push_back(pb);
    end
    lastFlush = fl;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, '0, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(txLevel == 0 && rxLevel == 0, "R11 levels", int'({txLevel, rxLevel}), 0);
    check(!cmdValid, "R11 cmdValid", int'(cmdValid), 0);
    check(txEmptyFlag && !rxFullFlag, "R11 thresh flags",
          int'({txEmptyFlag, rxFullFlag}), 2);
    check(!txOverFlag && !rxOverFlag && !rxUnderFlag, "R11 err flags",
          int'({txOverFlag, rxOverFlag, rxUnderFlag}), 0);
    @(negedge clk);
    rstN = 1'b1;
    idle();

    // R2: read requests with junk data, R1 flags
    step(1, 11'h1A5, 0, 0, 0, '0, 0);
    step(1, 11'h6C3, 0, 0, 0, '0, 0);
    step(1, 11'h23C, 0, 0, 0, '0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 0, 1, 0, '0, 0);

    // R6: fill, overflow, overflow while draining
    for (int i = 0; i < TXD; i++) step(1, 11'(i * 37 + 5), 0, 0, 0, '0, 0);
    step(1, 11'h0FF, 0, 0, 0, '0, 0);
    step(1, 11'h0EE, 0, 1, 0, '0, 0);
    idle();
    for (int i = 0; i < TXD; i++) step(0, '0, 0, 1, 0, '0, 0);

    // R8: read empty; R7 fill receive, overflow with pop
    step(0, '0, 1, 0, 0, '0, 0);
    idle();
    for (int i = 0; i < RXD; i++) step(0, '0, 0, 0, 1, 8'(i * 29 + 1), 0);
    step(0, '0, 0, 0, 1, 8'h77, 0);
    step(0, '0, 1, 0, 1, 8'h66, 0);
    idle();
    // R5 threshold sweep while draining
    for (int t = 0; t <= RXD; t++) begin
      rxThresh = LW'(t);
      txThresh = LW'(RXD - t);
      step(0, '0, 1, 0, 0, '0, 0);
    end

    // R10: flush with every access active
    for (int i = 0; i < 5; i++) step(1, 11'(i + 3), 0, 0, 1, 8'(i), 0);
    step(1, 11'h055, 1, 1, 1, 8'h99, 1);
    idle();
    step(0, '0, 1, 0, 0, '0, 0);
    idle();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 97) == 0) begin
        txThresh = LW'($urandom % (TXD + 1));
        rxThresh = LW'($urandom % (RXD + 1));
      end
      step(($urandom % 3) != 0, 11'($urandom), ($urandom % 3) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0, 8'($urandom),
           ($urandom % 64) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule